// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Engine

This block is the timing core of a master for a single open-drain data line that has a pull-up resistor. A host hands it one command at a time over a valid/ready handshake. Each command is a bus reset, a one-bit write or a one-bit read. The engine then produces the matching timed low pulse on the line and samples the line at a fixed point. When the slot and its recovery time have both ended, it raises a one-cycle done strobe. On that strobe it reports either a presence flag or the bit it read.

All timing is counted in whole microseconds. A clock divider, set by the `CLKS_PER_US` parameter, produces the microsecond tick. The line is modelled as a drive-low enable, so the engine never drives it high, and the line input passes through a two-flop synchroniser. Byte framing, ROM command sequences, CRC checking, strong pull-up and high-speed timing belong to the layers around this engine.

Top module: `swm_bit_master`

## Requirements
- R1: After synchronous reset, and while no command is in progress, `line_drive_low` is 0, `cmd_ready` is 1, `done` is 0 and `result_bit` is 0.
- R2: A reset command (`cmd_op` = 2'b00) drives the line low for exactly `RST_LOW_US` microseconds (490 by default), starting in the cycle right after acceptance.
- R3: For a reset command, `result_bit` is 1 when the synchronised line reads low `PRES_AT_US` microseconds after acceptance (560 by default, 70 after release). Otherwise it is 0.
- R4: A reset command ends with `done` exactly `RST_END_US` microseconds after acceptance (980 by default, 490 after release).
- R5: A write command (`cmd_op` = 2'b01) drives the line low for `W1_LOW_US` microseconds (6) when `cmd_bit` is 1 and for `W0_LOW_US` microseconds (62) when it is 0. Its `done` comes `SLOT_END_US` microseconds (67, which includes recovery) after acceptance.
- R6: A read command (`cmd_op[1]` = 1, so both 2'b10 and 2'b11) drives the line low for `RD_LOW_US` microseconds (2). It reports the synchronised line level sampled `RD_AT_US` microseconds (13) after acceptance, and signals `done` at `SLOT_END_US`.
- R7: `done` lasts exactly one cycle. `cmd_ready` is 0 from acceptance until `done`. A `cmd_valid` presented while `cmd_ready` is 0 is ignored: it changes neither the running slot nor anything that follows it.
- R8: A write command always returns `result_bit` = 0.
- R9: The line is released (`line_drive_low` = 0) in the cycle `done` is raised, and it stays released between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to accept a command |
| cmd_op | input | 2 | 00 bus reset, 01 write, 1x read |
| cmd_bit | input | 1 | Bit to write (write commands only) |
| line_in | input | 1 | Level on the shared line, asynchronous |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| done | output | 1 | One-cycle end-of-command strobe |
| result_bit | output | 1 | Presence flag (reset) or bit read (read), valid with done |

## Verification
A corrupted microsecond counter or a corrupted divider shows up as a wrong low-pulse width or a shifted `done` within the same command. The bench measures both to the clock cycle against values derived from the parameters. A wrong sample point makes the presence flag or the read bit flip: the bench's modelled responder holds the line low only for a bounded window, so a sample taken outside that window gives the opposite value at `done`. A broken busy state either leaks a second slot after a command that should have been ignored or lets `cmd_ready` rise early, and both are visible within one slot time.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int US_W = 12;

  typedef enum logic [1:0] {
    OP_BUS_RESET = 2'b00,
    OP_WRITE     = 2'b01,
    OP_READ      = 2'b10,
    OP_READ_ALT  = 2'b11
  } swm_op_e;

  typedef struct packed {
    logic [US_W-1:0] low_end;
    logic [US_W-1:0] sample_at;
    logic [US_W-1:0] end_at;
    logic            is_reset;
    logic            is_read;
  } swm_plan_t;
endpackage

// File: rtl/swm_tick_div.sv
module swm_tick_div #(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic tick
);
  localparam int DW = $clog2(CLKS_PER_US + 1);
  localparam logic [DW-1:0] LAST = DW'(CLKS_PER_US - 1);

  logic [DW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swm_sync2.sv
module swm_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swm_slot_timer.sv
module swm_slot_timer
  import swm_pkg::*;
#(
  parameter int CLKS_PER_US = 50
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  swm_plan_t plan,
  input  logic      line_s,
  output logic      busy,
  output logic      drive_low,
  output logic      done,
  output logic      result
);
  swm_plan_t       plan_q;
  logic [US_W-1:0] us_cnt;
  logic [US_W-1:0] us_nx;
  logic            tick;
  logic            smp;

  swm_tick_div #(.CLKS_PER_US(CLKS_PER_US)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clear(start),
    .en   (busy),
    .tick (tick)
  );

  always_comb begin
    us_nx = tick ? us_cnt + 1'b1 : us_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plan_q    <= '0;
      us_cnt    <= '0;
      busy      <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
      result    <= 1'b0;
      smp       <= 1'b1;
    end else begin
      done <= 1'b0;
      if (start) begin
        plan_q    <= plan;
        us_cnt    <= '0;
        busy      <= 1'b1;
        drive_low <= 1'b1;
        smp       <= 1'b1;
      end else if (busy) begin
        us_cnt    <= us_nx;
        drive_low <= (us_nx < plan_q.low_end);
        if (tick && us_nx == plan_q.sample_at) begin
          smp <= line_s;
        end
        if (tick && us_nx == plan_q.end_at) begin
          busy      <= 1'b0;
          drive_low <= 1'b0;
          done      <= 1'b1;
          if (plan_q.is_reset)     result <= ~smp;
          else if (plan_q.is_read) result <= smp;
          else                     result <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/swm_bit_master.sv
module swm_bit_master
  import swm_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int RST_LOW_US  = 490,
  parameter int PRES_AT_US  = 560,
  parameter int RST_END_US  = 980,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 62,
  parameter int RD_LOW_US   = 2,
  parameter int RD_AT_US    = 13,
  parameter int SLOT_END_US = 67
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       done,
  output logic       result_bit
);
  logic      busy;
  logic      accept;
  logic      line_s;
  swm_plan_t plan;

  assign cmd_ready = ~busy;
  assign accept    = cmd_valid && !busy;

  always_comb begin
    plan          = '0;
    plan.end_at   = US_W'(SLOT_END_US);
    plan.is_reset = 1'b0;
    plan.is_read  = 1'b0;
    unique casez (cmd_op)
      OP_BUS_RESET: begin
        plan.low_end   = US_W'(RST_LOW_US);
        plan.sample_at = US_W'(PRES_AT_US);
        plan.end_at    = US_W'(RST_END_US);
        plan.is_reset  = 1'b1;
      end
      OP_WRITE: begin
        plan.low_end   = cmd_bit ? US_W'(W1_LOW_US) : US_W'(W0_LOW_US);
        plan.sample_at = US_W'(RD_AT_US);
      end
      default: begin
        plan.low_end   = US_W'(RD_LOW_US);
        plan.sample_at = US_W'(RD_AT_US);
        plan.is_read   = 1'b1;
      end
    endcase
  end

  swm_sync2 #(.STAGES(2)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (line_in),
    .q  (line_s)
  );

  swm_slot_timer #(.CLKS_PER_US(CLKS_PER_US)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .plan     (plan),
    .line_s   (line_s),
    .busy     (busy),
    .drive_low(line_drive_low),
    .done     (done),
    .result   (result_bit)
  );
endmodule

// File: rtl/swm_bit_master_chk.sv
module swm_bit_master_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic line_drive_low,
  input logic done,
  input logic result_bit
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r2_low_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> line_drive_low);

  a_r9_release_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !line_drive_low);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !$past(cmd_ready && cmd_valid)) |-> !line_drive_low);

  a_r3_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ready && !done) |-> $stable(result_bit));
endmodule

bind swm_bit_master swm_bit_master_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .line_drive_low(line_drive_low),
  .done          (done),
  .result_bit    (result_bit)
);

// File: tb/swm_bit_master_test.sv
module swm_bit_master_test;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_bit = 1'b0;
  logic       line_in;
  logic       line_drive_low;
  logic       done;
  logic       result_bit;

  int checks = 0;
  int failures = 0;
  int slave_mode = 0;
  int pres_cnt = 0;
  int rd_cnt = 0;
  logic prev_drv = 1'b0;
  logic slave_low;

  always #10 clk = ~clk;

  swm_bit_master #(.CLKS_PER_US(N)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .line_in(line_in),
    .line_drive_low(line_drive_low), .done(done), .result_bit(result_bit)
  );

  // responder: mode 1 answers a reset with presence, mode 2 sends a zero bit
  always @(posedge clk) begin
    prev_drv <= line_drive_low;
    if (slave_mode == 1 && prev_drv && !line_drive_low) pres_cnt <= 1;
    else if (pres_cnt != 0 && pres_cnt < 200 * N)       pres_cnt <= pres_cnt + 1;
    else                                                pres_cnt <= 0;
    if (slave_mode == 2 && !prev_drv && line_drive_low) rd_cnt <= 1;
    else if (rd_cnt != 0 && rd_cnt < 30 * N)            rd_cnt <= rd_cnt + 1;
    else                                                rd_cnt <= 0;
  end

  assign slave_low = (pres_cnt >= 30 * N && pres_cnt < 150 * N) || (rd_cnt != 0);
  assign line_in   = !(line_drive_low || slave_low);

  typedef struct packed {
    logic [1:0]  op;
    logic        b;
    logic [1:0]  mode;
    logic [11:0] low_us;
    logic [11:0] end_us;
    logic        res;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 1'b0, 2'd0, 12'd490, 12'd980, 1'b0},
    '{2'b00, 1'b0, 2'd1, 12'd490, 12'd980, 1'b1},
    '{2'b01, 1'b1, 2'd0, 12'd6,   12'd67,  1'b0},
    '{2'b01, 1'b0, 2'd0, 12'd62,  12'd67,  1'b0},
    '{2'b10, 1'b0, 2'd0, 12'd2,   12'd67,  1'b1},
    '{2'b10, 1'b0, 2'd2, 12'd2,   12'd67,  1'b0},
    '{2'b11, 1'b0, 2'd2, 12'd2,   12'd67,  1'b0},
    '{2'b11, 1'b1, 2'd0, 12'd2,   12'd67,  1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic b, input int mode,
                        input bit poke, output int low, output int tot,
                        output logic res, output logic done_after);
    slave_mode = mode;
    @(negedge clk);
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    low = 0; tot = 0; res = 1'b0;
    if (line_drive_low) low++;
    while (tot < 10000) begin
      @(posedge clk);
      #1;
      tot++;
      if (poke && tot == 20) begin
        cmd_op = 2'b00; cmd_valid = 1'b1;
      end
      if (poke && tot == 22) cmd_valid = 1'b0;
      if (done) begin
        res = result_bit;
        break;
      end
      if (line_drive_low) low++;
    end
    @(posedge clk);
    #1 done_after = done;
    slave_mode = 0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int low, tot, idle_low;
    logic res, dn;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 drive after reset", int'(line_drive_low), 0);
    check("R1 ready after reset", int'(cmd_ready), 1);
    check("R1 done after reset", int'(done), 0);
    check("R1 result after reset", int'(result_bit), 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].op, VEC[i].b, int'(VEC[i].mode), 1'b0, low, tot, res, dn);
      if (VEC[i].op == 2'b00) begin
        check("R2 reset low cycles", low, int'(VEC[i].low_us) * N);
        check("R4 reset total cycles", tot, int'(VEC[i].end_us) * N);
        check("R3 presence flag", int'(res), int'(VEC[i].res));
      end else if (VEC[i].op == 2'b01) begin
        check("R5 write low cycles", low, int'(VEC[i].low_us) * N);
        check("R5 write total cycles", tot, int'(VEC[i].end_us) * N);
        check("R8 write result", int'(res), 0);
      end else begin
        check("R6 read low cycles", low, int'(VEC[i].low_us) * N);
        check("R6 read total cycles", tot, int'(VEC[i].end_us) * N);
        check("R6 read bit", int'(res), int'(VEC[i].res));
      end
      check("R7 done one cycle", int'(dn), 0);
      check("R9 released after done", int'(line_drive_low), 0);
    end

    // R7: command offered while busy is ignored
    run_op(2'b01, 1'b0, 0, 1'b1, low, tot, res, dn);
    check("R7 busy poke low cycles", low, 62 * N);
    check("R7 busy poke total cycles", tot, 67 * N);
    idle_low = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (line_drive_low || !cmd_ready) idle_low++;
    end
    check("R7 no slot after ignored command", idle_low, 0);

    // R1: reset in the middle of a bus reset releases the line
    @(negedge clk);
    cmd_op = 2'b00; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    check("R2 line low mid reset", int'(line_drive_low), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 line released by reset", int'(line_drive_low), 0);
    check("R1 ready after mid reset", int'(cmd_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule